// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one counting channel of a classic programmable interval timer. A configuration strobe selects one of six waveform modes and a second strobe loads a 16-bit period. The channel then counts on each cycle where the `tick` enable is high, and drives a waveform on `wave_out`. The count that a host would read is always present on `live_count`. The `gate` input can pause counting, or it can restart the period on a rising edge, depending on the mode. Byte sequencing, read latching, BCD arithmetic and bus decoding are handled by a neighbouring block. A single clock with a synchronous tick enable takes the place of a separate timer clock.

Both write strobes are single-cycle control pulses and are always accepted. The block has no data stream, so there is no valid/ready pair and no back-pressure.

In the requirements, N is the loaded period and E is the number of counting ticks since the last restart. A counting tick is a cycle in which `tick` is high, counting is not suspended, and no restart happens. The readable count is always taken modulo 65536.

Top module: `pit_timer_channel`

## Requirements
- R1: After reset the channel is in mode 3 with N = 65536, so `wave_out` is 1 and `live_count` is 0. The internal gate history resets high.
- R2: A loaded period value of 0 acts as N = 65536. For example, in mode 0 `wave_out` rises only after 65536 counting ticks.
- R3: Mode 0: `wave_out` = (E >= N) and `live_count` = N - E.
- R4: Mode 1: `wave_out` = (E < N) and `live_count` = N - E.
- R5: Mode 2: `wave_out` = 1 exactly when E is nonzero and a multiple of N, and `live_count` = N - (E mod N).
- R6: Mode 3: `wave_out` = ((E mod N) < (N+1)/2) and `live_count` = N - ((2E) mod N), so the count falls by two per tick.
- R7: Modes 4 and 5: `wave_out` = (E == N) and `live_count` = N - E.
- R8: In modes 1, 2, 3 and 5 a rising edge of `gate` (high now, low in the previous cycle) restarts counting, so E = 0 in the next cycle.
- R9: In modes 0, 2, 3 and 4 no tick is counted while `gate` is low. In modes 1 and 5 ticks are counted whatever the level of `gate`.
- R10: Mode codes 6 and 7 on `cfg_mode` behave exactly as modes 2 and 3.
- R11: A `cnt_we` or `cfg_we` strobe restarts counting (E = 0 from the next cycle) using the new value. When a strobe and a tick fall in the same cycle, the restart takes priority over the tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 3 | Mode code written by `cfg_we` |
| cnt_we | input | 1 | Period write strobe |
| cnt_val | input | 16 | Period value (0 means 65536) |
| gate | input | 1 | Gate level |
| tick | input | 1 | Count enable, one counting step per high cycle |
| wave_out | output | 1 | Channel output waveform |
| live_count | output | 16 | Current readable count |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that the mode and the period change only through the two write strobes, so any change of configuration comes with a restart. The stimulus drives all inputs at the falling edge. It changes `gate` in patterns that produce both pauses and clean rising edges, and it varies the tick density, so the held-count and retrigger properties are reached in every mode. The mode 2 pulse property is qualified on N > 1, and the stimulus includes periods from 2 to 6 as well as 65536.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;
  typedef enum logic [2:0] {
    MODE_TERMINAL  = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } pit_mode_e;

  // codes 6 and 7 fold onto the periodic modes
  function automatic pit_mode_e fold_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return pit_mode_e'({1'b0, code[1:0]});
    return pit_mode_e'(code);
  endfunction
endpackage

// File: rtl/pit_chan_ctrl.sv
module pit_chan_ctrl
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_mode,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             gate,
  input  logic             tick,
  output pit_mode_e        mode_eff,
  output logic [CNT_W:0]   period,
  output logic [CNT_W-1:0] load_val,
  output logic             restart,
  output logic             step
);
  localparam int FULL_W = CNT_W + 1;
  localparam logic [FULL_W-1:0] FULL_PERIOD = {1'b1, {CNT_W{1'b0}}};

  logic [2:0]       mode_q;
  logic [CNT_W-1:0] reload_q;
  logic             gate_q;
  logic             retrig_mode;
  logic             free_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 3'd3;
      reload_q <= '0;
      gate_q   <= 1'b1;
    end else begin
      if (cfg_we) mode_q <= cfg_mode;
      if (cnt_we) reload_q <= cnt_val;
      gate_q <= gate;
    end
  end

  always_comb begin
    mode_eff    = fold_mode(mode_q);
    period      = (reload_q == '0) ? FULL_PERIOD : {1'b0, reload_q};
    load_val    = cnt_we ? cnt_val : reload_q;
    retrig_mode = (mode_eff == MODE_ONESHOT) || (mode_eff == MODE_RATE) ||
                  (mode_eff == MODE_SQUARE)  || (mode_eff == MODE_HW_STROBE);
    free_mode   = (mode_eff == MODE_ONESHOT) || (mode_eff == MODE_HW_STROBE);
    restart     = cfg_we || cnt_we || (gate && !gate_q && retrig_mode);
    step        = tick && (gate || free_mode) && !restart;
  end

  assert_zero_is_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && cnt_val == '0) |=> (period == FULL_PERIOD));

  assert_gate_rise_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !gate_q && retrig_mode) |-> (restart && !step));
endmodule

// File: rtl/pit_oneshot_cnt.sv
module pit_oneshot_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] down_cnt,
  output logic             reached,
  output logic             passed
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      down_cnt <= '0;
      reached  <= 1'b0;
      passed   <= 1'b0;
    end else if (restart) begin
      down_cnt <= load_val;
      reached  <= 1'b0;
      passed   <= 1'b0;
    end else if (step) begin
      down_cnt <= down_cnt - ONE;
      reached  <= reached || (down_cnt == ONE);
      passed   <= reached;
    end
  end

  assert_terminal_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reached && !restart) |=> reached);

  assert_restart_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (down_cnt == $past(load_val)) && !reached && !passed);
endmodule

// File: rtl/pit_periodic_cnt.sv
module pit_periodic_cnt #(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           step,
  input  logic [CNT_W:0] period,
  output logic [CNT_W:0] phase,
  output logic           started
);
  localparam int FULL_W = CNT_W + 1;
  localparam logic [FULL_W-1:0] ONE = FULL_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      started <= 1'b0;
    end else if (restart) begin
      phase   <= '0;
      started <= 1'b0;
    end else if (step) begin
      phase   <= (phase == period - ONE) ? '0 : phase + ONE;
      started <= 1'b1;
    end
  end

  assert_phase_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase < period);
endmodule

// File: rtl/pit_timer_channel.sv
module pit_timer_channel
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_mode,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             gate,
  input  logic             tick,
  output logic             wave_out,
  output logic [CNT_W-1:0] live_count
);
  localparam int FULL_W = CNT_W + 1;
  localparam int DBL_W  = CNT_W + 2;
  localparam logic [FULL_W-1:0] ONE = FULL_W'(1);

  pit_mode_e        mode_eff;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] load_val;
  logic             restart;
  logic             step;
  logic [CNT_W-1:0] down_cnt;
  logic             reached;
  logic             passed;
  logic [CNT_W:0]   phase;
  logic             started;

  logic [DBL_W-1:0] dbl_phase;
  logic [DBL_W-1:0] dbl_red;
  logic [FULL_W-1:0] rate_left;
  logic [FULL_W-1:0] sq_left;
  logic [FULL_W-1:0] half_hi;

  pit_chan_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cnt_we(cnt_we), .cnt_val(cnt_val), .gate(gate), .tick(tick),
    .mode_eff(mode_eff), .period(period), .load_val(load_val),
    .restart(restart), .step(step)
  );

  pit_oneshot_cnt #(.CNT_W(CNT_W)) oneshot_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
    .load_val(load_val), .down_cnt(down_cnt), .reached(reached),
    .passed(passed)
  );

  pit_periodic_cnt #(.CNT_W(CNT_W)) periodic_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
    .period(period), .phase(phase), .started(started)
  );

  always_comb begin
    dbl_phase = {phase, 1'b0};
    dbl_red   = (dbl_phase >= {1'b0, period}) ? dbl_phase - {1'b0, period} : dbl_phase;
    rate_left = period - phase;
    sq_left   = period - dbl_red[FULL_W-1:0];
    half_hi   = (period + ONE) >> 1;
    case (mode_eff)
      MODE_TERMINAL: begin
        wave_out   = reached;
        live_count = down_cnt;
      end
      MODE_ONESHOT: begin
        wave_out   = !reached;
        live_count = down_cnt;
      end
      MODE_RATE: begin
        wave_out   = started && (phase == '0);
        live_count = rate_left[CNT_W-1:0];
      end
      MODE_SQUARE: begin
        wave_out   = phase < half_hi;
        live_count = sq_left[CNT_W-1:0];
      end
      default: begin
        wave_out   = reached && !passed;
        live_count = down_cnt;
      end
    endcase
  end

  assert_rate_pulse_one_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == MODE_RATE && period != ONE && wave_out && step) |=> !wave_out);

  assert_paused_count_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !restart && (mode_eff == MODE_TERMINAL || mode_eff == MODE_RATE ||
      mode_eff == MODE_SQUARE || mode_eff == MODE_SW_STROBE))
    |=> $stable(live_count) && $stable(wave_out));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_eff == MODE_SW_STROBE || mode_eff == MODE_HW_STROBE) && wave_out && step)
    |=> !wave_out);
endmodule

// File: tb/pit_timer_channel_tb_top.sv
module pit_timer_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_mode;
  logic        cnt_we;
  logic [15:0] cnt_val;
  logic        gate;
  logic        tick;
  logic        wave_out;
  logic [15:0] live_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_timer_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cnt_we(cnt_we), .cnt_val(cnt_val), .gate(gate), .tick(tick),
    .wave_out(wave_out), .live_count(live_count)
  );

  int    m_mode, m_n, m_e;
  bit    m_gprev;
  bit    g_cur;
  int    checks, fails;
  string ctx;
  bit    done;

  function automatic int fold(int m);
    return (m >= 6) ? m - 4 : m;
  endfunction

  function automatic string mode_req(int em);
    case (em)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_now();
    int em, eo, ec;
    em = fold(m_mode);
    case (em)
      0: begin eo = (m_e >= m_n); ec = (m_n - m_e) & 65535; end
      1: begin eo = (m_e < m_n);  ec = (m_n - m_e) & 65535; end
      2: begin eo = ((m_e % m_n) == 0 && m_e != 0); ec = (m_n - (m_e % m_n)) & 65535; end
      3: begin eo = ((m_e % m_n) < ((m_n + 1) / 2)); ec = (m_n - ((2 * m_e) % m_n)) & 65535; end
      default: begin eo = (m_e == m_n); ec = (m_n - m_e) & 65535; end
    endcase
    checks++;
    if (int'(wave_out) != eo || int'(live_count) != ec) begin
      fails++;
      $display("FAIL %s %s: out=%0d exp %0d count=%0d exp %0d (mode %0d N %0d E %0d)",
               ctx, mode_req(em), wave_out, eo, live_count, ec, m_mode, m_n, m_e);
    end
  endtask

  // one cycle: check outputs, drive inputs, advance the model
  task automatic cyc(bit cw, int md, bit nw, int v, bit g, bit t);
    int em;
    bit rise, retrig, freem, rs;
    @(negedge clk);
    check_now();
    cfg_we = cw; cfg_mode = 3'(md); cnt_we = nw; cnt_val = 16'(v);
    gate = g; tick = t; g_cur = g;
    em     = fold(m_mode);
    rise   = g && !m_gprev;
    retrig = (em == 1 || em == 2 || em == 3 || em == 5);
    freem  = (em == 1 || em == 5);
    rs     = cw || nw || (rise && retrig);
    if (cw) m_mode = md;
    if (nw) m_n = (v == 0) ? 65536 : v;
    if (rs) m_e = 0;
    else if (t && (g || freem)) m_e++;
    m_gprev = g;
  endtask

  task automatic spin(int n, bit g, int every);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b0, 0, g, (i % every) == 0);
  endtask

  task automatic set_mode(int md);
    cyc(1'b1, md, 1'b0, 0, g_cur, 1'b1);
  endtask

  task automatic set_count(int v);
    cyc(1'b0, 0, 1'b1, v, g_cur, 1'b1);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: out=%0d exp done count=%0d", wave_out, live_count);
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; cfg_we = 0; cfg_mode = 0; cnt_we = 0; cnt_val = 0;
    gate = 1'b1; tick = 1'b0; g_cur = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_mode = 3; m_n = 65536; m_e = 0; m_gprev = 1'b1;

    ctx = "R1 reset";
    cyc(1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    cyc(1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    spin(8, 1'b1, 1);

    ctx = "R3 terminal";
    set_mode(0); set_count(5);
    spin(12, 1'b1, 1);
    set_count(4);
    spin(10, 1'b1, 2);
    ctx = "R9 paused mode0";
    set_count(6);
    spin(3, 1'b1, 1); spin(5, 1'b0, 1); spin(8, 1'b1, 1);

    ctx = "R4 oneshot";
    set_mode(1); set_count(4);
    spin(8, 1'b1, 1);
    ctx = "R9 R8 oneshot gate";
    spin(3, 1'b0, 1); spin(2, 1'b1, 1); spin(6, 1'b1, 1);

    ctx = "R5 rate";
    set_mode(2); set_count(3);
    spin(14, 1'b1, 1);
    ctx = "R8 R9 rate gate";
    spin(2, 1'b0, 1); spin(7, 1'b1, 1); spin(9, 1'b1, 3);
    ctx = "R11 reload";
    set_count(5); spin(3, 1'b1, 1); set_count(2); spin(8, 1'b1, 1);
    ctx = "R5 rate N1";
    set_count(1); spin(5, 1'b1, 1);

    ctx = "R6 square odd";
    set_mode(3); set_count(5);
    spin(16, 1'b1, 1);
    ctx = "R6 square even";
    set_count(6);
    spin(16, 1'b1, 2);
    ctx = "R9 R8 square gate";
    spin(4, 1'b0, 1); spin(10, 1'b1, 1);

    ctx = "R7 sw strobe";
    set_mode(4); set_count(3);
    spin(8, 1'b1, 1);
    ctx = "R9 sw strobe gate";
    set_count(3); spin(1, 1'b1, 1); spin(4, 1'b0, 1); spin(6, 1'b1, 1);
    ctx = "R7 R8 hw strobe";
    set_mode(5); set_count(2);
    spin(6, 1'b1, 1); spin(2, 1'b0, 1); spin(6, 1'b1, 1);

    ctx = "R10 code6";
    set_mode(6); set_count(4);
    spin(12, 1'b1, 1); spin(2, 1'b0, 1); spin(5, 1'b1, 1);
    ctx = "R10 code7";
    set_mode(7); set_count(3);
    spin(12, 1'b1, 1);

    ctx = "R11 restart priority";
    set_mode(0); set_count(2);
    set_count(3); set_count(3); spin(6, 1'b1, 1);

    ctx = "R2 zero count";
    set_count(0);
    spin(65540, 1'b1, 1);
    ctx = "R2 zero count square";
    set_mode(3);
    spin(20, 1'b1, 1);

    @(negedge clk);
    check_now();
    done = 1;
    summary();
    $finish;
  end
endmodule